// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one compare channel placed next to a free-running timer counter. Each clock it compares the counter value with its active compare register. It then updates a registered reference waveform according to a 3-bit behaviour select. The available behaviours are hold, drive high or low on a match, invert on a match, hold low or high regardless of the count, and two pulse-width modes whose compare rule depends on the counting direction. The reference is active-high. A polarity input and a channel enable turn it into the pin-level output.

The compare value is written over a byte-wide path, high byte first. Writing the low byte commits the whole value to a preload register. With preload disabled, the same write also loads the active compare register, so it is used at once. With preload enabled, the active register picks up the preload value only on an update-event pulse from the counter, so a new duty cycle starts cleanly at a period boundary.

Timing: `ref_o` is a register. The mode, counter, direction and active compare value present before clock edge k decide the `ref_o` value seen after edge k. A compare write that commits at edge k is used from edge k+1 onward. `out_o` follows `ref_o`, `pol_i` and `chan_en_i` combinationally.

Top module: `oc_channel`

## Requirements
- R1: With mode 000, `ref_o` keeps its value, including on cycles where the counter equals the compare value.
- R2: With mode 001, a cycle where the counter equals the active compare value sets `ref_o` to 1. Other cycles leave it unchanged.
- R3: With mode 010, a cycle where the counter equals the active compare value clears `ref_o` to 0. Other cycles leave it unchanged.
- R4: Mode 100 drives `ref_o` to 0 and mode 101 drives it to 1, whatever the counter value.
- R5: With mode 011, each cycle where the counter equals the active compare value inverts `ref_o`. Other cycles leave it unchanged.
- R6: Mode 110 is the first pulse-width mode. When counting up (`cnt_down_i` = 0), `ref_o` becomes 1 if counter < compare and 0 otherwise. When counting down, `ref_o` becomes 0 if counter > compare and 1 otherwise.
- R7: Mode 111 is the second pulse-width mode. It produces the inverse of mode 110 in both counting directions.
- R8: With `preload_en_i` = 0, a compare value committed at edge k is the one compared from edge k+1 onward.
- R9: With `preload_en_i` = 1, a committed value does not reach the active compare register until an edge where `update_i` = 1. It is used from the following edge onward.
- R10: While enabled, `out_o` equals `ref_o` when `pol_i` = 0 and equals the inverse of `ref_o` when `pol_i` = 1.
- R11: With `chan_en_i` = 0, `out_o` holds the inactive level, which equals `pol_i`. `ref_o` keeps following the selected mode, so after re-enabling, `out_o` reflects the current reference at once.
- R12: A high-byte write (`wr_hi_i`) alone leaves the compare value in use unchanged. The low-byte write (`wr_lo_i`) commits {high byte, low byte} as one 16-bit value.
- R13: In mode 110 counting up, a compare value of 0 gives a constant-low reference for every count. A compare value above the last count of the period gives a constant-high reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_i | input | 16 | Current timer counter value |
| cnt_down_i | input | 1 | 1 while the counter counts down |
| update_i | input | 1 | One-cycle update-event pulse from the counter |
| mode_i | input | 3 | Reference behaviour select |
| preload_en_i | input | 1 | 1 = compare value changes only at an update event |
| pol_i | input | 1 | 1 = output is the inverted reference |
| chan_en_i | input | 1 | Channel output enable |
| wr_hi_i | input | 1 | Strobe: capture the compare high byte |
| wr_lo_i | input | 1 | Strobe: capture the low byte and commit the value |
| wr_byte_i | input | 8 | Byte written by the strobes |
| ref_o | output | 1 | Registered active-high reference waveform |
| out_o | output | 1 | Polarity-adjusted, enable-gated channel output |

## Verification
The bench builds the channel with its default parameters: a 16-bit counter and an 8-bit write byte. The split write path therefore has a real high and low half, and the counter range reaches 65535. With that width the bench can commit a value whose high byte is non-zero and show that the high byte alone changes nothing. It can also place the compare value at both range extremes. The 1000-count sweep with compare 1000 and the check at count 65535 with compare 0 cover the constant-high and constant-low edges of the first pulse-width mode.

// File: rtl/oc_pkg.sv
// Shared definitions for the output-compare channel.
// Assumes: the behaviour select is a 3-bit field whose codes are fixed by
// the surrounding timer's programming model.
package oc_pkg;

    typedef enum logic [2:0] {
        OC_HOLD      = 3'b000,
        OC_SET_EQ    = 3'b001,
        OC_CLR_EQ    = 3'b010,
        OC_FLIP_EQ   = 3'b011,
        OC_PIN_LOW   = 3'b100,
        OC_PIN_HIGH  = 3'b101,
        OC_PWM_A     = 3'b110,
        OC_PWM_B     = 3'b111
    } oc_mode_e;

endpackage

// File: rtl/oc_cmp_regs.sv
// Compare value storage: byte assembly, preload register and active register.
// Assumes: the high byte is written before the low byte, and
// CNT_W - BYTE_W <= BYTE_W. The low-byte strobe commits the whole value.
// update_i is a single-cycle pulse at the counter's period boundary.
module oc_cmp_regs #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              preload_en_i,
    input  logic              update_i,
    output logic [CNT_W-1:0]  cmp_o
);

    localparam int HI_W = CNT_W - BYTE_W;

    logic [CNT_W-1:0] wr_value;
    logic [CNT_W-1:0] preload_q;
    logic [CNT_W-1:0] active_q;

    generate
        if (HI_W > 0) begin : g_split
            logic [HI_W-1:0] hi_q;

            // Hold the high half until the committing low-byte write.
            always_ff @(posedge clk) begin
                if (!rst_n)       hi_q <= '0;
                else if (wr_hi_i) hi_q <= wr_byte_i[HI_W-1:0];
            end

            assign wr_value = {hi_q, wr_byte_i};
        end else begin : g_single
            logic unused_hi;
            assign unused_hi = wr_hi_i;
            assign wr_value  = wr_byte_i[CNT_W-1:0];
        end
    endgenerate

    // Preload register: takes every committed value.
    always_ff @(posedge clk) begin
        if (!rst_n)       preload_q <= '0;
        else if (wr_lo_i) preload_q <= wr_value;
    end

    // Active register: direct load when unbuffered, else transfer on update.
    always_ff @(posedge clk) begin
        if (!rst_n)                        active_q <= '0;
        else if (wr_lo_i && !preload_en_i) active_q <= wr_value;
        else if (update_i)                 active_q <= preload_q;
    end

    assign cmp_o = active_q;

    // R9: with buffering on, nothing but an update moves the active value.
    assert_preload_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en_i && !update_i) |=> $stable(active_q));

    // R9: an update transfers the pending preload value.
    assert_update_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en_i && update_i) |=> active_q == $past(preload_q));

    // R8: an unbuffered commit lands in both registers together.
    assert_direct_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !preload_en_i) |=> active_q == preload_q);

    // R12: a high-byte write on its own never changes the stored values.
    assert_hi_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !wr_lo_i && !update_i) |=> $stable(preload_q) && $stable(active_q));

endmodule

// File: rtl/oc_ref_gen.sv
// Reference waveform generator: decodes the behaviour select and updates a
// registered active-high reference once per clock.
// Assumes: cnt_i and cnt_down_i come from the timer counter in the same
// cycle, and cmp_i is the active compare value.
module oc_ref_gen
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  oc_mode_e         mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             ref_o
);

    logic ref_q;
    logic ref_d;
    logic hit;
    logic pwm_lvl;

    // Equality and direction-aware pulse-width level.
    always_comb begin
        hit     = (cnt_i == cmp_i);
        pwm_lvl = cnt_down_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i);
    end

    // Next reference value for the selected behaviour.
    always_comb begin
        ref_d = ref_q;
        unique case (mode_i)
            OC_HOLD:     ref_d = ref_q;
            OC_SET_EQ:   ref_d = hit ? 1'b1 : ref_q;
            OC_CLR_EQ:   ref_d = hit ? 1'b0 : ref_q;
            OC_FLIP_EQ:  ref_d = hit ? ~ref_q : ref_q;
            OC_PIN_LOW:  ref_d = 1'b0;
            OC_PIN_HIGH: ref_d = 1'b1;
            OC_PWM_A:    ref_d = pwm_lvl;
            OC_PWM_B:    ref_d = ~pwm_lvl;
            default:     ref_d = ref_q;
        endcase
    end

    // Reference register.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_d;
    end

    assign ref_o = ref_q;

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OC_HOLD) |=> $stable(ref_q));

    assert_set_eq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OC_SET_EQ && cnt_i == cmp_i) |=> ref_q);

    assert_clr_eq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OC_CLR_EQ && cnt_i == cmp_i) |=> !ref_q);

    assert_pin_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OC_PIN_LOW) |=> !ref_q);

    assert_pin_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OC_PIN_HIGH) |=> ref_q);

    assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OC_FLIP_EQ && cnt_i == cmp_i) |=> ref_q != $past(ref_q));

    assert_pwm_a_up_eq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OC_PWM_A && !cnt_down_i && cnt_i == cmp_i) |=> !ref_q);

    assert_pwm_a_dn_eq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OC_PWM_A && cnt_down_i && cnt_i == cmp_i) |=> ref_q);

    assert_pwm_b_up_eq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OC_PWM_B && !cnt_down_i && cnt_i == cmp_i) |=> ref_q);

    assert_pwm_a_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OC_PWM_A && !cnt_down_i && cmp_i == '0) |=> !ref_q);

endmodule

// File: rtl/oc_out_stage.sv
// Output stage: applies polarity and parks the pin at its inactive level
// while the channel is disabled.
// Assumes: the reference keeps running while the channel is disabled, so
// this stage holds no state.
module oc_out_stage (
    input  logic ref_i,
    input  logic pol_i,
    input  logic en_i,
    output logic out_o
);

    // Polarity and enable gating; inactive level equals the polarity bit.
    always_comb begin
        out_o = en_i ? (ref_i ^ pol_i) : pol_i;
    end

endmodule

// File: rtl/oc_channel.sv
// Output-compare channel top: compare storage, reference generator and
// output stage.
// Assumes: a timer counter outside this block supplies the count, the
// direction and the update pulse.
module oc_channel #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cnt_down_i,
    input  logic              update_i,
    input  logic [2:0]        mode_i,
    input  logic              preload_en_i,
    input  logic              pol_i,
    input  logic              chan_en_i,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    output logic              ref_o,
    output logic              out_o
);

    logic [CNT_W-1:0] cmp_act;
    logic             ref_w;
    oc_pkg::oc_mode_e mode_sel;

    // Map the raw select field onto the behaviour type.
    assign mode_sel = oc_pkg::oc_mode_e'(mode_i);

    oc_cmp_regs #(
        .CNT_W  (CNT_W),
        .BYTE_W (BYTE_W)
    ) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hi_i      (wr_hi_i),
        .wr_lo_i      (wr_lo_i),
        .wr_byte_i    (wr_byte_i),
        .preload_en_i (preload_en_i),
        .update_i     (update_i),
        .cmp_o        (cmp_act)
    );

    oc_ref_gen #(
        .CNT_W (CNT_W)
    ) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_sel),
        .cnt_i      (cnt_i),
        .cnt_down_i (cnt_down_i),
        .cmp_i      (cmp_act),
        .ref_o      (ref_w)
    );

    oc_out_stage u_out (
        .ref_i (ref_w),
        .pol_i (pol_i),
        .en_i  (chan_en_i),
        .out_o (out_o)
    );

    assign ref_o = ref_w;

    // R11: a disabled channel never shows the active level of the reference.
    assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en_i && ref_w) |-> (out_o == pol_i));

endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = '0;
    logic        dn = 1'b0;
    logic        upd = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic        pre = 1'b0;
    logic        pol = 1'b0;
    logic        en = 1'b1;
    logic        whi = 1'b0;
    logic        wlo = 1'b0;
    logic [7:0]  wbyte = '0;
    logic        ref_w;
    logic        out_w;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    oc_channel dut (
        .clk (clk), .rst_n (rst_n), .cnt_i (cnt), .cnt_down_i (dn),
        .update_i (upd), .mode_i (mode), .preload_en_i (pre), .pol_i (pol),
        .chan_en_i (en), .wr_hi_i (whi), .wr_lo_i (wlo), .wr_byte_i (wbyte),
        .ref_o (ref_w), .out_o (out_w)
    );

    // {req[24:21], mode[20:18], down[17], cnt[16:1], expected ref[0]}; compare = 100
    localparam logic [24:0] VEC [22] = '{
        {4'd4,  3'b101, 1'b0, 16'd0,   1'b1},  // R4 force high
        {4'd1,  3'b000, 1'b0, 16'd100, 1'b1},  // R1 hold through a match
        {4'd4,  3'b100, 1'b0, 16'd5,   1'b0},  // R4 force low
        {4'd1,  3'b000, 1'b0, 16'd100, 1'b0},  // R1
        {4'd2,  3'b001, 1'b0, 16'd99,  1'b0},  // R2 no match
        {4'd2,  3'b001, 1'b0, 16'd100, 1'b1},  // R2 match
        {4'd2,  3'b001, 1'b0, 16'd101, 1'b1},  // R2 stays
        {4'd3,  3'b010, 1'b0, 16'd50,  1'b1},  // R3 no match
        {4'd3,  3'b010, 1'b0, 16'd100, 1'b0},  // R3 match
        {4'd5,  3'b011, 1'b0, 16'd100, 1'b1},  // R5 flip
        {4'd5,  3'b011, 1'b0, 16'd101, 1'b1},  // R5 no match
        {4'd5,  3'b011, 1'b0, 16'd100, 1'b0},  // R5 flip back
        {4'd6,  3'b110, 1'b0, 16'd99,  1'b1},  // R6 up below
        {4'd6,  3'b110, 1'b0, 16'd100, 1'b0},  // R6 up equal
        {4'd6,  3'b110, 1'b0, 16'd101, 1'b0},  // R6 up above
        {4'd6,  3'b110, 1'b1, 16'd101, 1'b0},  // R6 down above
        {4'd6,  3'b110, 1'b1, 16'd100, 1'b1},  // R6 down equal
        {4'd6,  3'b110, 1'b1, 16'd0,   1'b1},  // R6 down below
        {4'd7,  3'b111, 1'b0, 16'd99,  1'b0},  // R7 up below
        {4'd7,  3'b111, 1'b0, 16'd100, 1'b1},  // R7 up equal
        {4'd7,  3'b111, 1'b1, 16'd100, 1'b0},  // R7 down equal
        {4'd7,  3'b111, 1'b1, 16'd101, 1'b1}   // R7 down above
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic wr_cmp(input logic [7:0] hi, input logic [7:0] lo);
        whi = 1'b1; wbyte = hi; tick();
        whi = 1'b0; wlo = 1'b1; wbyte = lo; tick();
        wlo = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int bad;
        repeat (3) tick();
        chk(ref_w, 1'b0, "reset", "ref_o in reset");
        chk(out_w, 1'b0, "reset", "out_o in reset");
        rst_n = 1'b1;
        wr_cmp(8'h00, 8'd100);

        for (int i = 0; i < 22; i++) begin
            mode = VEC[i][20:18]; dn = VEC[i][17]; cnt = VEC[i][16:1];
            tick();
            chk(ref_w, VEC[i][0], $sformatf("R%0d", VEC[i][24:21]), $sformatf("vector %0d", i));
        end
        dn = 1'b0;

        // R12: high byte alone leaves compare at 100; low byte commits 0x012C = 300
        mode = 3'b110; cnt = 16'd150;
        whi = 1'b1; wbyte = 8'h01; tick(); whi = 1'b0;
        tick();
        chk(ref_w, 1'b0, "R12", "high byte alone");
        wlo = 1'b1; wbyte = 8'h2C; tick(); wlo = 1'b0;
        tick();
        chk(ref_w, 1'b1, "R8", "unbuffered commit used next cycle");
        chk(ref_w, 1'b1, "R12", "16-bit value 300 committed");

        // R9: buffered write of 50 waits for the update pulse
        pre = 1'b1;
        wr_cmp(8'h00, 8'd50);
        cnt = 16'd100; tick();
        chk(ref_w, 1'b1, "R9", "old compare before update");
        upd = 1'b1; tick(); upd = 1'b0;
        chk(ref_w, 1'b1, "R9", "update edge uses old compare");
        tick();
        chk(ref_w, 1'b0, "R9", "new compare after update");
        pre = 1'b0;

        // R13: compare 0 gives constant low, compare 1000 over a 0..999 period constant high
        wr_cmp(8'h00, 8'h00);
        cnt = 16'd0; tick();
        chk(ref_w, 1'b0, "R13", "compare 0 at count 0");
        cnt = 16'hFFFF; tick();
        chk(ref_w, 1'b0, "R13", "compare 0 at count 65535");
        wr_cmp(8'h03, 8'hE8);
        bad = 0;
        for (int c = 0; c < 1000; c++) begin
            cnt = 16'(c); tick();
            if (ref_w !== 1'b1) bad++;
        end
        chk(bad == 0, 1'b1, "R13", "compare above period always high");

        // R10: polarity
        mode = 3'b101; tick();
        chk(out_w, 1'b1, "R10", "pol 0 passes reference");
        pol = 1'b1; #1;
        chk(out_w, 1'b0, "R10", "pol 1 inverts reference");

        // R11: disabled output parks at pol, reference keeps running
        en = 1'b0; pol = 1'b0; #1;
        chk(out_w, 1'b0, "R11", "disabled, pol 0");
        pol = 1'b1; #1;
        chk(out_w, 1'b1, "R11", "disabled, pol 1");
        mode = 3'b100; tick();
        chk(ref_w, 1'b0, "R11", "reference runs while disabled");
        chk(out_w, 1'b1, "R11", "still idle level");
        mode = 3'b101; tick();
        pol = 1'b0; en = 1'b1; #1;
        chk(out_w, 1'b1, "R11", "re-enable shows current reference");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule